// File: doc/BRIEF.md
# Exception Detection and Vector Selection Unit

This block sits beside the completion stage of a processor pipeline. Every cycle it looks at the decode flags of the instruction that is completing, the machine-state control bits, the floating-point exception summary bit, the current decrementer value and the results of the instruction-side and data-side translation lookups. From these inputs it decides whether an exception is taken, picks one when several apply, and registers the fixed vector offset of that exception. For the program exception it also registers a one-hot cause word that tells the subtypes apart.

A take is reported with a one-cycle `exc_take` pulse. The offset and the cause word then stay on the outputs until the surrounding control logic raises `exc_ack`. While they are held, no new exception is taken. A decrementer event stays pending through that time and is taken later. Saving and restoring registers, decoding instructions and the translation buffers themselves are handled outside this block.

Top module: `exc_vector_unit`

## Requirements
- R1: A taken exception registers its offset one clock after the cycle in which it is detected. The offsets are: instruction translation miss 0x01000, program 0x00700, floating-point unavailable 0x00800, system call 0x00C00, data load miss 0x01100, data store miss 0x01200, trace 0x00D00, decrementer 0x00900.
- R2: While a take is held, the offset is never 0x00E00 and never falls in 0x00A00–0x00BFF or 0x00E10–0x00FFF.
- R3: Floating-point unavailable is raised when `op_fp` is set, including a floating-point load or store, and `msr_fp` is 0.
- R4: A decrementer event becomes pending when bit DEC_W-1 of `dec_value` is 1 and was 0 in the previous cycle. The event is taken only while `msr_ee` is 1. It stays pending until it is taken.
- R5: Trace is raised when `msr_se` is 1, or when `op_branch` and `msr_be` are both 1.
- R6: A floating-point-enabled program exception is raised when (`msr_fe0` | `msr_fe1`) & `fpscr_fex` is 1. It sets cause bit 0.
- R7: A privileged program exception is raised while `msr_pr` is 1 when `op_priv` is set, or when `op_spr_move`, `spr_invalid` and `spr_top_bit` are all set. It sets cause bit 2.
- R8: A data store miss is raised for `op_store` when `dtlb_hit` is 0, or when `dtlb_hit` is 1 and `pte_changed` is 0. A data load miss is raised for `op_load` when `dtlb_hit` is 0, and load is checked before store.
- R9: An illegal opcode sets cause bit 1 and a met trap condition sets cause bit 3. The cause word is one-hot and its subtypes rank illegal, privileged, trap, floating-point-enabled. The cause word is zero for every exception that is not a program exception.
- R10: When several exceptions apply, the one taken ranks highest in this order: instruction miss, program, floating-point unavailable, system call, data load, data store, trace, decrementer.
- R11: After a take, the offset and cause hold, and no further take occurs, until `exc_ack` is sampled high. The next cycle both outputs then read zero.
- R12: After reset all outputs are zero and no decrementer event is pending. The previous decrementer MSB is taken as 1, so a reset with the MSB already set raises no event.
- R13: With `cmpl_valid` at 0, no exception other than the decrementer is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_valid | input | 1 | An instruction is completing this cycle |
| op_fp | input | 1 | Instruction is floating point (including FP load/store) |
| op_load | input | 1 | Instruction performs a data load |
| op_store | input | 1 | Instruction performs a data store |
| op_branch | input | 1 | Instruction is a branch |
| op_syscall | input | 1 | Instruction is a system call |
| op_illegal | input | 1 | Illegal opcode or opcode combination |
| op_priv | input | 1 | Instruction is privileged |
| op_spr_move | input | 1 | Move to or from a special register |
| spr_invalid | input | 1 | The special-register field names no valid register |
| spr_top_bit | input | 1 | Top bit of the special-register field |
| trap_met | input | 1 | Trap instruction condition is met |
| msr_ee | input | 1 | External/decrementer enable |
| msr_pr | input | 1 | User privilege state |
| msr_fp | input | 1 | Floating-point available |
| msr_se | input | 1 | Single-step trace enable |
| msr_be | input | 1 | Branch trace enable |
| msr_fe0 | input | 1 | FP exception mode bit 0 |
| msr_fe1 | input | 1 | FP exception mode bit 1 |
| fpscr_fex | input | 1 | FP enabled-exception summary |
| dec_value | input | DEC_W | Current decrementer value |
| itlb_hit | input | 1 | Instruction fetch translation hit |
| dtlb_hit | input | 1 | Data access translation hit |
| pte_changed | input | 1 | Change bit of the matching page entry is set |
| exc_ack | input | 1 | Releases the held exception outputs |
| exc_take | output | 1 | One-cycle pulse when an exception is taken |
| exc_vector | output | 20 | Vector offset of the taken exception |
| exc_cause | output | 4 | One-hot program subtype |

## Verification
The decrementer event and an instruction-borne exception can fall into the same cycle. The event can also arrive while an earlier take is still held. The bench provokes both cases: it wraps a decrementer countdown through zero at random points among random completing instructions, and directed steps line an MSB rise up with an instruction miss and with a held take. The bench judges the outcome with a model of the pending flag. The instruction exception must win, the decrementer must stay pending, and it must be taken as soon as the hold is acknowledged and `msr_ee` allows.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int VEC_W   = 20;
    localparam int CAUSE_W = 4;
    localparam int EXC_N   = 8;

    // request index: lower index wins
    localparam int IDX_ISI  = 0;
    localparam int IDX_PROG = 1;
    localparam int IDX_FPU  = 2;
    localparam int IDX_SC   = 3;
    localparam int IDX_DLD  = 4;
    localparam int IDX_DST  = 5;
    localparam int IDX_TRC  = 6;
    localparam int IDX_DEC  = 7;

    // program cause bit positions
    localparam int CB_FPE  = 0;
    localparam int CB_ILL  = 1;
    localparam int CB_PRIV = 2;
    localparam int CB_TRAP = 3;

    typedef struct packed {
        logic               busy;
        logic               take;
        logic [VEC_W-1:0]   vec;
        logic [CAUSE_W-1:0] cause;
        logic               dec_prev;
        logic               dec_pend;
    } exc_state_t;

    function automatic logic [VEC_W-1:0] offset_of(input int idx);
        case (idx)
            IDX_ISI:  offset_of = 20'h01000;
            IDX_PROG: offset_of = 20'h00700;
            IDX_FPU:  offset_of = 20'h00800;
            IDX_SC:   offset_of = 20'h00C00;
            IDX_DLD:  offset_of = 20'h01100;
            IDX_DST:  offset_of = 20'h01200;
            IDX_TRC:  offset_of = 20'h00D00;
            default:  offset_of = 20'h00900;
        endcase
    endfunction

endpackage

// File: rtl/exc_cond.sv
module exc_cond
    import exc_pkg::*;
(
    input  logic               cmpl_valid,
    input  logic               op_fp,
    input  logic               op_load,
    input  logic               op_store,
    input  logic               op_branch,
    input  logic               op_syscall,
    input  logic               op_illegal,
    input  logic               op_priv,
    input  logic               op_spr_move,
    input  logic               spr_invalid,
    input  logic               spr_top_bit,
    input  logic               trap_met,
    input  logic               msr_pr,
    input  logic               msr_fp,
    input  logic               msr_se,
    input  logic               msr_be,
    input  logic               msr_fe0,
    input  logic               msr_fe1,
    input  logic               fpscr_fex,
    input  logic               itlb_hit,
    input  logic               dtlb_hit,
    input  logic               pte_changed,
    input  logic               dec_req,
    output logic [EXC_N-1:0]   req,
    output logic [CAUSE_W-1:0] prog_cause
);

    logic fpe_c, ill_c, priv_c, trap_c;

    always_comb begin
        fpe_c  = cmpl_valid & (msr_fe0 | msr_fe1) & fpscr_fex;
        ill_c  = cmpl_valid & op_illegal;
        priv_c = cmpl_valid & msr_pr &
                 (op_priv | (op_spr_move & spr_invalid & spr_top_bit));
        trap_c = cmpl_valid & trap_met;

        // one-hot subtype, ranked illegal > privileged > trap > fp-enabled
        prog_cause = '0;
        if (ill_c)       prog_cause[CB_ILL]  = 1'b1;
        else if (priv_c) prog_cause[CB_PRIV] = 1'b1;
        else if (trap_c) prog_cause[CB_TRAP] = 1'b1;
        else if (fpe_c)  prog_cause[CB_FPE]  = 1'b1;

        req           = '0;
        req[IDX_ISI]  = cmpl_valid & ~itlb_hit;
        req[IDX_PROG] = ill_c | priv_c | trap_c | fpe_c;
        req[IDX_FPU]  = cmpl_valid & op_fp & ~msr_fp;
        req[IDX_SC]   = cmpl_valid & op_syscall;
        req[IDX_DLD]  = cmpl_valid & op_load & ~dtlb_hit;
        req[IDX_DST]  = cmpl_valid & op_store & (~dtlb_hit | ~pte_changed);
        req[IDX_TRC]  = cmpl_valid & (msr_se | (op_branch & msr_be));
        req[IDX_DEC]  = dec_req;
    end

endmodule

// File: rtl/exc_prio.sv
module exc_prio #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    assign grant[0] = req[0];

    for (genvar i = 1; i < N; i++) begin : g_rank
        assign grant[i] = req[i] & ~(|req[i-1:0]);
    end

    assign any = |req;

    // R10: at most one winner, and a winner whenever something asks
    a_r10_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (grant != '0)));

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl_valid,
    input  logic             op_fp,
    input  logic             op_load,
    input  logic             op_store,
    input  logic             op_branch,
    input  logic             op_syscall,
    input  logic             op_illegal,
    input  logic             op_priv,
    input  logic             op_spr_move,
    input  logic             spr_invalid,
    input  logic             spr_top_bit,
    input  logic             trap_met,
    input  logic             msr_ee,
    input  logic             msr_pr,
    input  logic             msr_fp,
    input  logic             msr_se,
    input  logic             msr_be,
    input  logic             msr_fe0,
    input  logic             msr_fe1,
    input  logic             fpscr_fex,
    input  logic [DEC_W-1:0] dec_value,
    input  logic             itlb_hit,
    input  logic             dtlb_hit,
    input  logic             pte_changed,
    input  logic             exc_ack,
    output logic             exc_take,
    output logic [19:0]      exc_vector,
    output logic [3:0]       exc_cause
);

    localparam int MSB = DEC_W - 1;

    exc_state_t st_d, st_q;

    logic               dec_rise, dec_live, dec_req, any_req, fire;
    logic [EXC_N-1:0]   req, grant;
    logic [CAUSE_W-1:0] prog_cause;
    logic [VEC_W-1:0]   win_vec;

    always_comb begin
        dec_rise = dec_value[MSB] & ~st_q.dec_prev;
        dec_live = st_q.dec_pend | dec_rise;
        dec_req  = dec_live & msr_ee;
    end

    exc_cond u_cond (
        .cmpl_valid  (cmpl_valid),
        .op_fp       (op_fp),
        .op_load     (op_load),
        .op_store    (op_store),
        .op_branch   (op_branch),
        .op_syscall  (op_syscall),
        .op_illegal  (op_illegal),
        .op_priv     (op_priv),
        .op_spr_move (op_spr_move),
        .spr_invalid (spr_invalid),
        .spr_top_bit (spr_top_bit),
        .trap_met    (trap_met),
        .msr_pr      (msr_pr),
        .msr_fp      (msr_fp),
        .msr_se      (msr_se),
        .msr_be      (msr_be),
        .msr_fe0     (msr_fe0),
        .msr_fe1     (msr_fe1),
        .fpscr_fex   (fpscr_fex),
        .itlb_hit    (itlb_hit),
        .dtlb_hit    (dtlb_hit),
        .pte_changed (pte_changed),
        .dec_req     (dec_req),
        .req         (req),
        .prog_cause  (prog_cause)
    );

    exc_prio #(.N(EXC_N)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant),
        .any   (any_req)
    );

    always_comb begin
        win_vec = '0;
        for (int i = 0; i < EXC_N; i++) begin
            if (grant[i]) win_vec = win_vec | offset_of(i);
        end
    end

    always_comb begin
        fire          = any_req & ~st_q.busy;
        st_d          = st_q;
        st_d.take     = fire;
        st_d.dec_prev = dec_value[MSB];
        st_d.dec_pend = dec_live & ~(fire & grant[IDX_DEC]);
        if (fire) begin
            st_d.busy  = 1'b1;
            st_d.vec   = win_vec;
            st_d.cause = grant[IDX_PROG] ? prog_cause : '0;
        end else if (st_q.busy && exc_ack) begin
            st_d.busy  = 1'b0;
            st_d.vec   = '0;
            st_d.cause = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.dec_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_take   = st_q.take;
    assign exc_vector = st_q.vec;
    assign exc_cause  = st_q.cause;

    // R2: reserved offsets never appear
    a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !(exc_vector >= 20'h00A00 && exc_vector <= 20'h00BFF) &&
                      !(exc_vector >= 20'h00E00 && exc_vector <= 20'h00FFF));

    // R9: cause is one-hot and only accompanies the program offset
    a_r9_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exc_cause) && ((exc_cause != '0) -> (exc_vector == 20'h00700)));

    // R11: held outputs stay put and no new take until acknowledged
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !exc_ack) |=> (!exc_take && $stable(exc_vector) && $stable(exc_cause)));

    // R11: acknowledge clears the outputs
    a_r11_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && exc_ack) |=> (exc_vector == '0 && exc_cause == '0 && !exc_take));

    // R4: a pending decrementer event survives until it is granted
    a_r4_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dec_pend && !(fire && grant[IDX_DEC])) |=> st_q.dec_pend);

    // R13: no instruction-borne request without a completing instruction
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmpl_valid |-> (req[IDX_DEC-1:0] == '0));

endmodule

// File: tb/exc_vector_unit_tb_top.sv
module exc_vector_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEC_W      = 32;
    localparam int N_RAND     = 4000;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n;
    logic cmpl_valid, op_fp, op_load, op_store, op_branch, op_syscall;
    logic op_illegal, op_priv, op_spr_move, spr_invalid, spr_top_bit, trap_met;
    logic msr_ee, msr_pr, msr_fp, msr_se, msr_be, msr_fe0, msr_fe1, fpscr_fex;
    logic [DEC_W-1:0] dec_value;
    logic itlb_hit, dtlb_hit, pte_changed, exc_ack;
    logic        exc_take;
    logic [19:0] exc_vector;
    logic [3:0]  exc_cause;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model
    logic        m_busy, m_prev, m_pend;
    logic [19:0] m_vec;
    logic [3:0]  m_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_vector_unit #(.DEC_W(DEC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .op_fp(op_fp),
        .op_load(op_load), .op_store(op_store), .op_branch(op_branch),
        .op_syscall(op_syscall), .op_illegal(op_illegal), .op_priv(op_priv),
        .op_spr_move(op_spr_move), .spr_invalid(spr_invalid),
        .spr_top_bit(spr_top_bit), .trap_met(trap_met), .msr_ee(msr_ee),
        .msr_pr(msr_pr), .msr_fp(msr_fp), .msr_se(msr_se), .msr_be(msr_be),
        .msr_fe0(msr_fe0), .msr_fe1(msr_fe1), .fpscr_fex(fpscr_fex),
        .dec_value(dec_value), .itlb_hit(itlb_hit), .dtlb_hit(dtlb_hit),
        .pte_changed(pte_changed), .exc_ack(exc_ack), .exc_take(exc_take),
        .exc_vector(exc_vector), .exc_cause(exc_cause)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic [19:0] v);
        case (v)
            20'h01000: tag_of = "R1/R10 instr miss";
            20'h00700: tag_of = "R6/R7/R9 program";
            20'h00800: tag_of = "R3 fp unavailable";
            20'h00C00: tag_of = "R1 syscall";
            20'h01100: tag_of = "R8 load miss";
            20'h01200: tag_of = "R8 store miss";
            20'h00D00: tag_of = "R5 trace";
            20'h00900: tag_of = "R4 decrementer";
            default:   tag_of = "R11/R13 none";
        endcase
    endfunction

    task automatic clear_inputs();
        cmpl_valid = 0; op_fp = 0; op_load = 0; op_store = 0; op_branch = 0;
        op_syscall = 0; op_illegal = 0; op_priv = 0; op_spr_move = 0;
        spr_invalid = 0; spr_top_bit = 0; trap_met = 0; msr_ee = 0; msr_pr = 0;
        msr_fp = 1; msr_se = 0; msr_be = 0; msr_fe0 = 0; msr_fe1 = 0;
        fpscr_fex = 0; itlb_hit = 1; dtlb_hit = 1; pte_changed = 1; exc_ack = 0;
    endtask

    // one cycle: predict from inputs (set at negedge), compare after posedge
    task automatic step();
        logic rise, live, fire, ill, priv, trap, fpe, prog;
        logic [19:0] v;
        logic [3:0]  c;
        logic exp_take;
        string tag;
        rise = dec_value[DEC_W-1] && !m_prev;
        live = m_pend || rise;
        ill  = cmpl_valid && op_illegal;
        priv = cmpl_valid && msr_pr && (op_priv || (op_spr_move && spr_invalid && spr_top_bit));
        trap = cmpl_valid && trap_met;
        fpe  = cmpl_valid && (msr_fe0 || msr_fe1) && fpscr_fex;
        prog = ill || priv || trap || fpe;
        c = ill ? 4'b0010 : priv ? 4'b0100 : trap ? 4'b1000 : fpe ? 4'b0001 : 4'b0000;
        v = 20'h0;
        if (cmpl_valid && !itlb_hit)                                v = 20'h01000;
        else if (prog)                                              v = 20'h00700;
        else if (cmpl_valid && op_fp && !msr_fp)                    v = 20'h00800;
        else if (cmpl_valid && op_syscall)                          v = 20'h00C00;
        else if (cmpl_valid && op_load && !dtlb_hit)                v = 20'h01100;
        else if (cmpl_valid && op_store && (!dtlb_hit || !pte_changed)) v = 20'h01200;
        else if (cmpl_valid && (msr_se || (op_branch && msr_be)))  v = 20'h00D00;
        else if (live && msr_ee)                                    v = 20'h00900;
        if (v != 20'h00700) c = 4'b0000;
        fire = !m_busy && (v != 20'h0);
        exp_take = fire;
        if (fire) begin
            m_busy = 1; m_vec = v; m_cause = c;
        end else if (m_busy && exc_ack) begin
            m_busy = 0; m_vec = 0; m_cause = 0;
        end
        m_pend = live && !(fire && v == 20'h00900);
        m_prev = dec_value[DEC_W-1];
        @(posedge clk);
        #1;
        tag = tag_of(m_vec);
        check({tag, " take"},  {31'b0, exc_take}, {31'b0, exp_take});
        check({tag, " vector"}, {12'b0, exc_vector}, {12'b0, m_vec});
        check({tag, " cause"},  {28'b0, exc_cause}, {28'b0, m_cause});
        @(negedge clk);
    endtask

    task automatic ack_cycle();
        clear_inputs();
        exc_ack = 1;
        step();
        clear_inputs();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        clear_inputs();
        dec_value = {1'b1, {(DEC_W-1){1'b0}}};   // MSB already set during reset
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_busy = 0; m_vec = 0; m_cause = 0; m_prev = 1; m_pend = 0;
        // R12: reset state
        check("R12 reset take", {31'b0, exc_take}, 32'd0);
        check("R12 reset vector", {12'b0, exc_vector}, 32'd0);
        check("R12 reset cause", {28'b0, exc_cause}, 32'd0);
        // R12: MSB high out of reset raises nothing even with EE
        msr_ee = 1;
        step();
        step();
        check("R12 no dec after reset", {31'b0, exc_take}, 32'd0);

        // R3: fp load with FP disabled; R1 offset
        clear_inputs();
        cmpl_valid = 1; op_fp = 1; op_load = 1; msr_fp = 0; dtlb_hit = 0;
        step();
        check("R3 fp unavailable offset", {12'b0, exc_vector}, 32'h00800);
        // R11: held without ack, new request ignored
        clear_inputs();
        cmpl_valid = 1; op_syscall = 1;
        step();
        check("R11 held offset", {12'b0, exc_vector}, 32'h00800);
        ack_cycle();
        check("R11 cleared after ack", {12'b0, exc_vector}, 32'd0);

        // R8: store hit with change bit clear
        cmpl_valid = 1; op_store = 1; dtlb_hit = 1; pte_changed = 0;
        step();
        check("R8 store change-bit offset", {12'b0, exc_vector}, 32'h01200);
        ack_cycle();

        // R7: invalid SPR move with top bit in user state
        cmpl_valid = 1; op_spr_move = 1; spr_invalid = 1; spr_top_bit = 1; msr_pr = 1;
        fpscr_fex = 1; msr_fe1 = 1;
        step();
        check("R7/R9 privileged cause", {28'b0, exc_cause}, 32'h4);
        ack_cycle();

        // R13: nothing without a completing instruction
        op_illegal = 1; op_syscall = 1; msr_se = 1; itlb_hit = 0;
        step();
        check("R13 idle no take", {31'b0, exc_take}, 32'd0);
        clear_inputs();

        // R4/R10: MSB rise together with instruction miss, then held take
        dec_value = '0;
        step();
        msr_ee = 1;
        dec_value = {1'b1, {(DEC_W-1){1'b0}}};
        cmpl_valid = 1; itlb_hit = 0; op_syscall = 1;
        step();
        check("R10 miss beats decrementer", {12'b0, exc_vector}, 32'h01000);
        cmpl_valid = 0; itlb_hit = 1; op_syscall = 0;
        step();
        check("R4 pending while held", {31'b0, exc_take}, 32'd0);
        exc_ack = 1; msr_ee = 0;
        step();
        exc_ack = 0;
        step();
        check("R4 EE low blocks", {31'b0, exc_take}, 32'd0);
        msr_ee = 1;
        step();
        check("R4 pending taken", {12'b0, exc_vector}, 32'h00900);
        ack_cycle();
        msr_ee = 1;

        // constrained random
        begin
            int reload_in;
            reload_in = 5;
            for (int n = 0; n < N_RAND; n++) begin
                cmpl_valid  = ($urandom % 10) < 7;
                op_fp       = ($urandom % 10) == 0;
                op_load     = ($urandom % 8) == 0;
                op_store    = !op_load && (($urandom % 8) == 0);
                op_branch   = ($urandom % 5) == 0;
                op_syscall  = ($urandom % 20) == 0;
                op_illegal  = ($urandom % 25) == 0;
                op_priv     = ($urandom % 15) == 0;
                op_spr_move = ($urandom % 10) == 0;
                spr_invalid = ($urandom % 2) == 0;
                spr_top_bit = ($urandom % 2) == 0;
                trap_met    = ($urandom % 25) == 0;
                msr_ee      = ($urandom % 2) == 0;
                msr_pr      = ($urandom % 2) == 0;
                msr_fp      = ($urandom % 5) != 0;
                msr_se      = ($urandom % 20) == 0;
                msr_be      = ($urandom % 5) == 0;
                msr_fe0     = ($urandom % 5) == 0;
                msr_fe1     = ($urandom % 5) == 0;
                fpscr_fex   = ($urandom % 10) == 0;
                itlb_hit    = ($urandom % 12) != 0;
                dtlb_hit    = ($urandom % 6) != 0;
                pte_changed = ($urandom % 3) != 0;
                exc_ack     = ($urandom % 3) == 0;
                if (--reload_in == 0) begin
                    dec_value = DEC_W'($urandom % 12);
                    reload_in = 20 + ($urandom % 30);
                end else begin
                    dec_value = dec_value - 1'b1;
                end
                step();
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule